// File: doc/BRIEF.md
# Channel Command Executor with Revision-Handshake Reset

This block takes one-byte commands that a host writes into a command register and carries them out against the control state of a small multi-channel serial controller. Three reset-class operations are available: reset one channel, reset the whole controller, and flush the transmit FIFO of one channel. A fourth class copies host-edited channel option registers into the internal shadow copies of those registers. The serial datapaths and the FIFO storage are not part of the block. It drives only their enable lines and their flush or pointer-reset strobes.

The target channel is taken from a channel-select input at the moment the command is written. While a command is executing, the command register reads back the written byte and a busy flag is raised. When the command finishes, the register reads zero. Reset completion is reported through a revision register. A fixed number of cycles after a reset command is accepted, this register drops to zero. After the reset interval it is reloaded with a nonzero revision constant. A host therefore polls for zero and then for nonzero. It may also clear the register itself first and then wait for nonzero.

Top module: `chan_cmd_exec`

## Requirements
- R1: After the hardware reset input is released, every receive and transmit enable, every flush output, the busy flag, the command readback, every option register and every shadow register are zero, and the revision register holds REV_VAL.
- R2: A legal command written while idle is accepted. From the next cycle until it finishes, cmd_rdata shows the written byte and busy is high. A command write made while busy is ignored and does not change the byte or the target channel.
- R3: An illegal byte is dropped with no effect: busy stays low, cmd_rdata stays zero, and no enable, option, shadow or revision value changes. A byte is illegal when it has bit 7 set and any of bits 6:2 set, when bits 1:0 are 11 with bit 7 set, when bits 7 and 6 are both set, when bit 7 is clear and any of bits 5, 4 or 0 is set, or when bits 7 and 6 are both clear.
- R4: Command 0x80 (channel reset) acts START_DLY cycles after acceptance. The revision register goes to zero, and the target channel's receive and transmit enables clear. Its receive and transmit flush outputs stay high for RST_LEN cycles. Other channels are untouched.
- R5: RST_LEN cycles after a reset starts, the revision register loads REV_VAL, cmd_rdata returns to zero, busy falls, and the flush outputs drop.
- R6: Command 0x81 (full reset) acts START_DLY cycles after acceptance. It disables and flushes every channel, zeroes every option and shadow register, and clears the revision register. Completion is as in R5.
- R7: Command 0x82 (transmit flush) raises txf_flush of the target channel alone for exactly one cycle, START_DLY cycles after acceptance. At that point the command completes. Enables and the revision register are unchanged.
- R8: A byte with bit 7 clear, bit 6 set and bits 5, 4 and 0 clear is an option-change command. START_DLY cycles after acceptance, it copies option register 1, 2 or 3 of the target channel into that channel's shadow when bit 3, 2 or 1 is set, respectively. It then completes. Unflagged shadows keep their values.
- R9: Host writes set the revision register while no reset is running. A value of zero written before a reset stays zero until the reset's completion loads REV_VAL.
- R10: The target channel is the value of chan_sel on the cycle the command is written. Later changes of chan_sel do not redirect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_sel | input | CH_W | Channel addressed by host writes and new commands |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command byte |
| cmd_rdata | output | 8 | Command register readback, zero when idle |
| busy | output | 1 | A command is executing |
| rev_we | input | 1 | Revision register write strobe |
| rev_wdata | input | 8 | Revision register write value |
| rev_rdata | output | 8 | Revision register value |
| en_we | input | 1 | Enable write for the selected channel |
| en_wdata | input | 2 | Bit 1 receive enable, bit 0 transmit enable |
| opt_we | input | 1 | Option register write for the selected channel |
| opt_sel | input | 2 | Option register index: 0, 1, 2 for registers 1, 2, 3 |
| opt_wdata | input | 8 | Option write value |
| opt_rdata | output | 8 | Host-visible option register at chan_sel and opt_sel |
| rx_en | output | NUM_CH | Per-channel receiver enable |
| tx_en | output | NUM_CH | Per-channel transmitter enable |
| rxf_flush | output | NUM_CH | Per-channel receive FIFO flush and pointer reset |
| txf_flush | output | NUM_CH | Per-channel transmit FIFO flush and pointer reset |
| shadow_flat | output | NUM_CH*24 | Shadow copies; channel c, register k at bits (c*3+k)*8 +: 8 |

## Verification
Acceptance takes one edge, so the readback and busy are checked one cycle after the write. Start effects are due exactly START_DLY edges after acceptance: the revision zero, the cleared enables, the raised flushes, the one-cycle transmit flush and the shadow copy. Completion of a reset is due RST_LEN edges after that. The bench drives on falling edges and counts falling edges from the write strobe, so each expected value is sampled half a period after the exact edge that should produce it. A write made during the busy window checks that neither the byte nor the target moves.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;
   localparam int NUM_OPT = 3;

   typedef enum logic [2:0] {
      K_NONE,
      K_CHRST,
      K_FULLRST,
      K_TXFLUSH,
      K_OPTCHG
   } cmd_kind_e;

   typedef struct packed {
      cmd_kind_e  kind;
      logic [2:0] flags;
   } cmd_dec_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
   import chan_cmd_pkg::*;
(
   input  logic [7:0] byte_in,
   output cmd_dec_t   dec
);
   always_comb begin
      dec = '{kind: K_NONE, flags: 3'b000};
      if (byte_in[7] && byte_in[6:2] == 5'b0) begin
         unique case (byte_in[1:0])
            2'b00:   dec.kind = K_CHRST;
            2'b01:   dec.kind = K_FULLRST;
            2'b10:   dec.kind = K_TXFLUSH;
            default: dec.kind = K_NONE;
         endcase
      end else if (!byte_in[7] && byte_in[6] && byte_in[5:4] == 2'b00 && !byte_in[0]) begin
         dec.kind  = K_OPTCHG;
         dec.flags = byte_in[3:1];
      end
   end
endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
   import chan_cmd_pkg::*;
#(
   parameter int          DW        = 8,
   parameter int          CH_W      = 2,
   parameter int          START_DLY = 4,
   parameter int          RST_LEN   = 16,
   parameter logic [7:0]  REV_VAL   = 8'h5C
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_we,
   input  logic [DW-1:0]   cmd_wdata,
   input  cmd_dec_t        dec,
   input  logic [CH_W-1:0] chan_sel,
   input  logic            rev_we,
   input  logic [DW-1:0]   rev_wdata,
   output logic [DW-1:0]   cmd_q,
   output logic [DW-1:0]   rev_q,
   output logic            busy,
   output logic            start_p,
   output logic            end_p,
   output cmd_kind_e       kind_q,
   output logic [2:0]      flags_q,
   output logic [CH_W-1:0] chan_q
);
   localparam int MAXC  = (START_DLY > RST_LEN) ? START_DLY : RST_LEN;
   localparam int CNT_W = $clog2(MAXC + 1);

   typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RST} seq_state_e;

   seq_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             accept;
   logic             is_reset;

   assign accept   = cmd_we && (state == S_IDLE) && (dec.kind != K_NONE);
   assign is_reset = (kind_q == K_CHRST) || (kind_q == K_FULLRST);
   assign busy     = (state != S_IDLE);
   assign start_p  = (state == S_WAIT) && (cnt == '0);
   assign end_p    = (state == S_RST) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         cnt     <= '0;
         cmd_q   <= '0;
         rev_q   <= REV_VAL;
         kind_q  <= K_NONE;
         flags_q <= '0;
         chan_q  <= '0;
      end else begin
         if (rev_we && state != S_RST) rev_q <= rev_wdata;
         unique case (state)
            S_IDLE: begin
               if (accept) begin
                  cmd_q   <= cmd_wdata;
                  kind_q  <= dec.kind;
                  flags_q <= dec.flags;
                  chan_q  <= chan_sel;
                  cnt     <= CNT_W'(START_DLY - 1);
                  state   <= S_WAIT;
               end
            end
            S_WAIT: begin
               if (cnt == '0) begin
                  if (is_reset) begin
                     rev_q <= '0;
                     cnt   <= CNT_W'(RST_LEN - 1);
                     state <= S_RST;
                  end else begin
                     cmd_q <= '0;
                     state <= S_IDLE;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            S_RST: begin
               if (cnt == '0) begin
                  rev_q <= REV_VAL;
                  cmd_q <= '0;
                  state <= S_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assert_cmd_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_IDLE) |-> (cmd_q != '0));
   assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_IDLE && !start_p && !end_p) |=> ($stable(cmd_q) && $stable(chan_q)));
   assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE) |-> (cmd_q == '0));
   assert_rev_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RST) |-> (rev_q == '0));
   assert_done_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      end_p |=> (rev_q == REV_VAL && state == S_IDLE));
endmodule

// File: rtl/chan_ctrl.sv
module chan_ctrl
   import chan_cmd_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel_hit,
   input  logic                  tgt_hit,
   input  logic                  en_we,
   input  logic [1:0]            en_wdata,
   input  logic                  opt_we,
   input  logic [1:0]            opt_idx,
   input  logic [DW-1:0]         opt_wdata,
   input  logic                  start_p,
   input  logic                  end_p,
   input  cmd_kind_e             kind,
   input  logic [2:0]            flags,
   output logic                  rx_en,
   output logic                  tx_en,
   output logic                  rxf_flush,
   output logic                  txf_flush,
   output logic [NUM_OPT*DW-1:0] opt_flat,
   output logic [NUM_OPT*DW-1:0] shadow_flat
);
   logic [DW-1:0] opt_r [NUM_OPT];
   logic [DW-1:0] shd_r [NUM_OPT];
   logic          rst_hold;
   logic          tx_pulse;
   logic          rst_go;
   logic          full_go;
   logic          copy_go;

   assign full_go = start_p && (kind == K_FULLRST);
   assign rst_go  = full_go || (start_p && kind == K_CHRST && tgt_hit);
   assign copy_go = start_p && (kind == K_OPTCHG) && tgt_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en    <= 1'b0;
         tx_en    <= 1'b0;
         rst_hold <= 1'b0;
         tx_pulse <= 1'b0;
         for (int k = 0; k < NUM_OPT; k++) begin
            opt_r[k] <= '0;
            shd_r[k] <= '0;
         end
      end else begin
         tx_pulse <= start_p && (kind == K_TXFLUSH) && tgt_hit;
         if (end_p) rst_hold <= 1'b0;
         if (en_we && sel_hit && !rst_hold) {rx_en, tx_en} <= en_wdata;
         if (opt_we && sel_hit && opt_idx < 2'(NUM_OPT)) opt_r[opt_idx] <= opt_wdata;
         if (copy_go) begin
            for (int k = 0; k < NUM_OPT; k++)
               if (flags[NUM_OPT-1-k]) shd_r[k] <= opt_r[k];
         end
         if (rst_go) begin
            rx_en    <= 1'b0;
            tx_en    <= 1'b0;
            rst_hold <= 1'b1;
         end
         if (full_go) begin
            for (int k = 0; k < NUM_OPT; k++) begin
               opt_r[k] <= '0;
               shd_r[k] <= '0;
            end
         end
      end
   end

   assign rxf_flush = rst_hold;
   assign txf_flush = rst_hold | tx_pulse;

   for (genvar k = 0; k < NUM_OPT; k++) begin : g_flat
      assign opt_flat[k*DW +: DW]    = opt_r[k];
      assign shadow_flat[k*DW +: DW] = shd_r[k];
   end

   assert_off_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_hold |-> (!rx_en && !tx_en));
   assert_flush_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pulse |=> !tx_pulse);
   assert_full_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      full_go |=> (opt_flat == '0 && shadow_flat == '0));
endmodule

// File: rtl/chan_cmd_exec.sv
module chan_cmd_exec
   import chan_cmd_pkg::*;
#(
   parameter int         NUM_CH    = 4,
   parameter int         START_DLY = 4,
   parameter int         RST_LEN   = 16,
   parameter logic [7:0] REV_VAL   = 8'h5C,
   localparam int        DW        = 8,
   localparam int        CH_W      = $clog2(NUM_CH),
   localparam int        SH_W      = NUM_CH * NUM_OPT * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_W-1:0]   chan_sel,
   input  logic              cmd_we,
   input  logic [DW-1:0]     cmd_wdata,
   output logic [DW-1:0]     cmd_rdata,
   output logic              busy,
   input  logic              rev_we,
   input  logic [DW-1:0]     rev_wdata,
   output logic [DW-1:0]     rev_rdata,
   input  logic              en_we,
   input  logic [1:0]        en_wdata,
   input  logic              opt_we,
   input  logic [1:0]        opt_sel,
   input  logic [DW-1:0]     opt_wdata,
   output logic [DW-1:0]     opt_rdata,
   output logic [NUM_CH-1:0] rx_en,
   output logic [NUM_CH-1:0] tx_en,
   output logic [NUM_CH-1:0] rxf_flush,
   output logic [NUM_CH-1:0] txf_flush,
   output logic [SH_W-1:0]   shadow_flat
);
   initial begin
      assert (NUM_CH >= 2) else $error("NUM_CH must be at least 2");
      assert (START_DLY >= 2) else $error("START_DLY must be at least 2");
      assert (RST_LEN >= 1) else $error("RST_LEN must be at least 1");
      assert (REV_VAL != 8'h00) else $error("REV_VAL must be nonzero");
   end

   cmd_dec_t        dec;
   logic            start_p;
   logic            end_p;
   cmd_kind_e       kind_q;
   logic [2:0]      flags_q;
   logic [CH_W-1:0] chan_q;
   logic [NUM_OPT*DW-1:0] opt_all [NUM_CH];

   cmd_decode u_dec (
      .byte_in (cmd_wdata),
      .dec     (dec)
   );

   cmd_sequencer #(
      .DW        (DW),
      .CH_W      (CH_W),
      .START_DLY (START_DLY),
      .RST_LEN   (RST_LEN),
      .REV_VAL   (REV_VAL)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_we    (cmd_we),
      .cmd_wdata (cmd_wdata),
      .dec       (dec),
      .chan_sel  (chan_sel),
      .rev_we    (rev_we),
      .rev_wdata (rev_wdata),
      .cmd_q     (cmd_rdata),
      .rev_q     (rev_rdata),
      .busy      (busy),
      .start_p   (start_p),
      .end_p     (end_p),
      .kind_q    (kind_q),
      .flags_q   (flags_q),
      .chan_q    (chan_q)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      chan_ctrl #(.DW(DW)) u_ch (
         .clk         (clk),
         .rst_n       (rst_n),
         .sel_hit     (chan_sel == CH_W'(i)),
         .tgt_hit     (chan_q == CH_W'(i)),
         .en_we       (en_we),
         .en_wdata    (en_wdata),
         .opt_we      (opt_we),
         .opt_idx     (opt_sel),
         .opt_wdata   (opt_wdata),
         .start_p     (start_p),
         .end_p       (end_p),
         .kind        (kind_q),
         .flags       (flags_q),
         .rx_en       (rx_en[i]),
         .tx_en       (tx_en[i]),
         .rxf_flush   (rxf_flush[i]),
         .txf_flush   (txf_flush[i]),
         .opt_flat    (opt_all[i]),
         .shadow_flat (shadow_flat[i*NUM_OPT*DW +: NUM_OPT*DW])
      );
   end

   always_comb begin
      opt_rdata = '0;
      if ({1'b0, chan_sel} < (CH_W+1)'(NUM_CH) && opt_sel < 2'(NUM_OPT))
         opt_rdata = opt_all[chan_sel][opt_sel*DW +: DW];
   end

   assert_tx_flush_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(txf_flush & ~rxf_flush));
   assert_flush_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rxf_flush != '0) |-> busy);
endmodule

// File: tb/chan_cmd_exec_test.sv
module chan_cmd_exec_test;
   localparam int         NCH = 4;
   localparam int         D   = 4;
   localparam int         L   = 16;
   localparam logic [7:0] REV = 8'h5C;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      chan_sel = '0;
   logic            cmd_we = 1'b0;
   logic [7:0]      cmd_wdata = '0;
   logic [7:0]      cmd_rdata;
   logic            busy;
   logic            rev_we = 1'b0;
   logic [7:0]      rev_wdata = '0;
   logic [7:0]      rev_rdata;
   logic            en_we = 1'b0;
   logic [1:0]      en_wdata = '0;
   logic            opt_we = 1'b0;
   logic [1:0]      opt_sel = '0;
   logic [7:0]      opt_wdata = '0;
   logic [7:0]      opt_rdata;
   logic [NCH-1:0]  rx_en, tx_en, rxf_flush, txf_flush;
   logic [NCH*24-1:0] shadow_flat;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 0;
   bit   m_rx [NCH];
   bit   m_tx [NCH];
   logic [7:0] m_opt [NCH][3];
   logic [7:0] m_sh [NCH][3];
   logic [7:0] m_rev;

   always #2 clk = ~clk;

   chan_cmd_exec #(.NUM_CH(NCH), .START_DLY(D), .RST_LEN(L), .REV_VAL(REV)) uut (
      .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .cmd_we(cmd_we),
      .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .busy(busy),
      .rev_we(rev_we), .rev_wdata(rev_wdata), .rev_rdata(rev_rdata),
      .en_we(en_we), .en_wdata(en_wdata), .opt_we(opt_we), .opt_sel(opt_sel),
      .opt_wdata(opt_wdata), .opt_rdata(opt_rdata), .rx_en(rx_en), .tx_en(tx_en),
      .rxf_flush(rxf_flush), .txf_flush(txf_flush), .shadow_flat(shadow_flat)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   // 0 illegal, 1 channel reset, 2 full reset, 3 tx flush, 4 option change
   function automatic int classify(logic [7:0] b);
      if (b[7] && b[6:2] == 0) return (b[1:0] == 2'b11) ? 0 : 1 + int'(b[1:0]);
      if (!b[7] && b[6] && b[5:4] == 0 && !b[0]) return 4;
      return 0;
   endfunction

   task automatic check_state(string req);
      for (int c = 0; c < NCH; c++) begin
         chk(req, $sformatf("rx_en[%0d]", c), int'(rx_en[c]), int'(m_rx[c]));
         chk(req, $sformatf("tx_en[%0d]", c), int'(tx_en[c]), int'(m_tx[c]));
         for (int k = 0; k < 3; k++)
            chk(req, $sformatf("shadow[%0d][%0d]", c, k),
                int'(shadow_flat[(c*3+k)*8 +: 8]), int'(m_sh[c][k]));
      end
      chk(req, "rev", int'(rev_rdata), int'(m_rev));
   endtask

   task automatic check_opts(string req);
      for (int c = 0; c < NCH; c++)
         for (int k = 0; k < 3; k++) begin
            chan_sel = 2'(c);
            opt_sel  = 2'(k);
            #1;
            chk(req, $sformatf("opt[%0d][%0d]", c, k), int'(opt_rdata), int'(m_opt[c][k]));
         end
      step(1);
   endtask

   task automatic host_en(int ch, logic [1:0] v);
      chan_sel = 2'(ch); en_wdata = v; en_we = 1'b1;
      step(1);
      en_we = 1'b0;
      m_rx[ch] = v[1]; m_tx[ch] = v[0];
   endtask

   task automatic host_opt(int ch, int k, logic [7:0] v);
      chan_sel = 2'(ch); opt_sel = 2'(k); opt_wdata = v; opt_we = 1'b1;
      step(1);
      opt_we = 1'b0;
      m_opt[ch][k] = v;
   endtask

   task automatic host_rev(logic [7:0] v);
      rev_wdata = v; rev_we = 1'b1;
      step(1);
      rev_we = 1'b0;
      m_rev = v;
      chk("R9", "rev after host write", int'(rev_rdata), int'(v));
   endtask

   task automatic run_cmd(logic [7:0] b, int ch, bit poke);
      int k = classify(b);
      chan_sel = 2'(ch); cmd_wdata = b; cmd_we = 1'b1;
      step(1);
      cmd_we = 1'b0;
      if (k == 0) begin
         chk("R3", "cmd_rdata after illegal", int'(cmd_rdata), 0);
         chk("R3", "busy after illegal", int'(busy), 0);
         step(D + 1);
         chk("R3", "flush after illegal", int'({rxf_flush, txf_flush}), 0);
         check_state("R3");
         return;
      end
      chk("R2", "cmd_rdata while busy", int'(cmd_rdata), int'(b));
      chk("R2", "busy after accept", int'(busy), 1);
      if (poke) begin
         cmd_wdata = 8'h81; chan_sel = 2'((ch + 1) % NCH); cmd_we = 1'b1;
         step(1);
         cmd_we = 1'b0;
         chk("R2", "cmd_rdata after busy write", int'(cmd_rdata), int'(b));
         step(D - 1);
      end else begin
         step(D);
      end
      if (k == 1 || k == 2) begin
         m_rev = 8'h00;
         for (int c = 0; c < NCH; c++) begin
            bit hit = (k == 2) || (c == ch);
            if (hit) begin
               m_rx[c] = 0; m_tx[c] = 0;
               if (k == 2)
                  for (int j = 0; j < 3; j++) begin m_opt[c][j] = '0; m_sh[c][j] = '0; end
            end
            chk(k == 2 ? "R6" : "R4", $sformatf("rxf_flush[%0d]", c), int'(rxf_flush[c]), int'(hit));
            chk(k == 2 ? "R6" : "R4", $sformatf("txf_flush[%0d] R10", c), int'(txf_flush[c]), int'(hit));
         end
         check_state(k == 2 ? "R6" : "R4");
         chk("R4", "busy during reset", int'(busy), 1);
         step(L - 1);
         chk("R5", "rev still zero before end", int'(rev_rdata), 0);
         step(1);
         m_rev = REV;
         chk("R5", "rev loaded", int'(rev_rdata), int'(REV));
         chk("R5", "busy after reset", int'(busy), 0);
         chk("R5", "cmd_rdata after reset", int'(cmd_rdata), 0);
         chk("R5", "flushes after reset", int'({rxf_flush, txf_flush}), 0);
      end else if (k == 3) begin
         for (int c = 0; c < NCH; c++) begin
            chk("R7", $sformatf("txf_flush[%0d]", c), int'(txf_flush[c]), int'(c == ch));
            chk("R7", $sformatf("rxf_flush[%0d]", c), int'(rxf_flush[c]), 0);
         end
         chk("R7", "busy after flush", int'(busy), 0);
         chk("R7", "cmd_rdata after flush", int'(cmd_rdata), 0);
         check_state("R7");
         step(1);
         chk("R7", "txf_flush one cycle", int'(txf_flush), 0);
      end else begin
         for (int j = 0; j < 3; j++)
            if (b[3-j]) m_sh[ch][j] = m_opt[ch][j];
         chk("R8", "busy after option change", int'(busy), 0);
         chk("R8", "cmd_rdata after option change", int'(cmd_rdata), 0);
         check_state("R8");
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R5 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < NCH; c++) begin
         m_rx[c] = 0; m_tx[c] = 0;
         for (int j = 0; j < 3; j++) begin m_opt[c][j] = '0; m_sh[c][j] = '0; end
      end
      m_rev = REV;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1: power-on state
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "cmd_rdata", int'(cmd_rdata), 0);
      chk("R1", "flushes", int'({rxf_flush, txf_flush}), 0);
      check_state("R1");
      check_opts("R1");

      for (int c = 0; c < NCH; c++) begin
         host_en(c, 2'b11);
         for (int j = 0; j < 3; j++) host_opt(c, j, 8'(16 * c + j + 1));
      end
      // R8: flags for registers 1 and 3 only
      run_cmd(8'h4A, 1, 0);
      run_cmd(8'h44, 2, 0);
      // R9 then R4/R5 with a write during busy (R2, R10)
      host_rev(8'h00);
      run_cmd(8'h80, 2, 1);
      host_en(2, 2'b10);
      // R7
      run_cmd(8'h82, 3, 1);
      // R3 illegal patterns
      run_cmd(8'h83, 0, 0);
      run_cmd(8'hC1, 0, 0);
      run_cmd(8'h90, 1, 0);
      run_cmd(8'h50, 1, 0);
      run_cmd(8'h00, 1, 0);
      check_opts("R3");
      // R6
      run_cmd(8'h81, 0, 0);
      check_opts("R6");

      for (int it = 0; it < 80; it++) begin
         int r = int'($urandom % 7);
         int ch = int'($urandom % NCH);
         logic [7:0] b;
         case (r)
            0: host_en(ch, 2'($urandom));
            1: host_opt(ch, int'($urandom % 3), 8'($urandom));
            2: b = 8'h80 | 8'($urandom % 4);
            3: b = 8'h40 | {4'b0, 3'($urandom), 1'b0};
            4: b = 8'($urandom);
            5: b = 8'h40 | 8'($urandom % 64);
            default: b = 8'h82;
         endcase
         if (r >= 2) run_cmd(b, ch, bit'($urandom % 2));
         if (it % 10 == 9) check_opts("R8");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule